// File: doc/BRIEF.md
# PHY Control-Bus Handshake Master

This block runs the four-phase request/acknowledge protocol that a serial-link PHY uses on its control bus. A host issues one command at a time through a start/busy/done interface: load a 16-bit register address into the PHY, write a 16-bit value to the addressed register, or read the addressed register back. The block drives the PHY data-in bus and one of four strobes: capture-address, capture-data, write and read. It watches the PHY acknowledge line and data-out bus, and finishes with a one-cycle done pulse plus an error flag.

Every strobe is a full handshake. The strobe is raised, acknowledge is polled until it is high, the strobe is lowered, and acknowledge is polled until it is low. Polls are spaced `POLL_GAP` clock cycles apart. At most `MAX_POLLS` polls are made per wait. If the budget runs out, the command is aborted with an error and its later steps never run. A write whose value has bit `RESET_BIT` set resets the PHY, and a resetting PHY cannot answer. For that write, the block raises the write strobe, leaves it up and reports completion without waiting.

The controller is one state machine. Its states are `ST_IDLE` (waiting for a command), `ST_HI` (strobe high, polling for acknowledge high) and `ST_LO` (strobe low, polling for acknowledge low). Its transitions are:
- accept: `ST_IDLE`→`ST_HI`
- reserved code: `ST_IDLE`→`ST_IDLE`, with done and error
- acked: `ST_HI`→`ST_LO`
- hi-timeout: `ST_HI`→`ST_IDLE`
- released-next: `ST_LO`→`ST_HI`, from capture-data to write
- reset-park: `ST_LO`→`ST_IDLE`, write strobe left high
- released-done: `ST_LO`→`ST_IDLE`
- lo-timeout: `ST_LO`→`ST_IDLE`

Top module: `phy_cr_master`

## Requirements
- R1: After reset, busy, done, error, every strobe, the data-in bus and the read-data output are all zero.
- R2: Command code 0 (address) puts the operand on the data-in bus and runs one full handshake on the capture-address strobe. It then pulses done with error 0.
- R3: Command code 1 (write) puts the operand on the data-in bus and runs a full handshake on capture-data. Only after that handshake does it run a full handshake on the write strobe.
- R4: Command code 2 (read) runs a full handshake on the read strobe. The read-data output takes the data-out bus as sampled by the poll that first sees acknowledge high, and holds it until the next read.
- R5: Each acknowledge wait makes at most `MAX_POLLS` polls, spaced `POLL_GAP` cycles apart, with the first poll one cycle after the wait begins. When a PHY never acknowledges, done arrives 1+(`MAX_POLLS`-1)·`POLL_GAP` cycles after the start is taken, with error 1.
- R6: A timeout ends the command with every strobe low. The remaining steps are not run; a write that times out during capture-data never raises the write strobe.
- R7: If bit 0 of the write value is set, done (error 0) follows the capture-data handshake at once, with the write strobe high. The write strobe stays high until the next command is accepted.
- R8: Only one command runs at a time. A start while busy is ignored. Done is high for exactly one cycle per command, busy is low when done is high, and the error flag is valid alongside done.
- R9: Command code 3 is reserved. It gives done with error 1 in the cycle after the start and touches no strobe.
- R10: At most one strobe is high at any time. The data-in bus does not change while the same strobe stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command request, taken only when idle |
| cmd_i | input | 2 | Command code: 0 address, 1 write, 2 read, 3 reserved |
| operand_i | input | DATA_W | Address or write value |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout or reserved-code error, valid with done |
| rdata_o | output | DATA_W | Last value read from the PHY |
| phy_din_o | output | DATA_W | Data-in bus to the PHY |
| phy_cap_addr_o | output | 1 | Capture-address strobe |
| phy_cap_data_o | output | 1 | Capture-data strobe |
| phy_wr_o | output | 1 | Write strobe |
| phy_rd_o | output | 1 | Read strobe |
| phy_ack_i | input | 1 | PHY acknowledge |
| phy_dout_i | input | DATA_W | PHY data-out bus |

## Verification
The main handshake is tried against a responder whose acknowledge latency is drawn at random per command, across random mixes of address, write and read commands with random operands. This separates a controller that really waits for each edge of acknowledge from one that works only at a fixed timing. Directed patterns cover the remaining failure modes:
- A responder that never acknowledges tells a correct poll budget and spacing apart from an off-by-one, through the exact done latency.
- A responder whose acknowledge sticks high checks that a release timeout blocks the later write step.
- A reset-bit write checks the no-wait completion and the parked write strobe.
- A start pulse during a slow command shows whether a busy controller ignores it.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

    // Host command codes (cmd_i)
    typedef enum logic [1:0] {
        CMD_ADDR  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2,
        CMD_RSVD  = 2'd3
    } cr_cmd_e;

    // Strobe select; value is the bit index in the strobe vector
    typedef enum logic [1:0] {
        STB_CAP_ADDR = 2'd0,
        STB_CAP_DATA = 2'd1,
        STB_WRITE    = 2'd2,
        STB_READ     = 2'd3
    } cr_strobe_e;

    localparam int unsigned NUM_STROBES = 4;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HI   = 2'd1,
        ST_LO   = 2'd2
    } cr_state_e;

endpackage

// File: rtl/phy_cr_poll_timer.sv
module phy_cr_poll_timer #(
    parameter int unsigned POLL_GAP  = 4,
    parameter int unsigned MAX_POLLS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic active_i,
    output logic poll_o,
    output logic last_o
);

    localparam int unsigned GAP_W  = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
    localparam int unsigned CNT_W  = $clog2(MAX_POLLS + 1);
    localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(POLL_GAP - 1);
    localparam logic [CNT_W-1:0] LAST_IDX   = CNT_W'(MAX_POLLS - 1);

    logic [GAP_W-1:0] gap_q;
    logic [CNT_W-1:0] polls_q;

    // A poll is due whenever the spacing counter has run down
    assign poll_o = active_i && (gap_q == '0);
    assign last_o = (polls_q == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q   <= '0;
            polls_q <= '0;
        end else if (restart_i) begin
            gap_q   <= '0;
            polls_q <= '0;
        end else if (poll_o) begin
            gap_q   <= GAP_RELOAD;
            polls_q <= polls_q + 1'b1;
        end else if (active_i) begin
            gap_q   <= gap_q - 1'b1;
        end
    end

endmodule

// File: rtl/phy_cr_strobe_drv.sv
module phy_cr_strobe_drv
    import phy_cr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   on_i,
    input  cr_strobe_e             sel_i,
    output logic [NUM_STROBES-1:0] strobe_o
);

    // One flop per strobe; each is high only when selected and enabled
    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_stb
        logic stb_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stb_q <= 1'b0;
            end else begin
                stb_q <= on_i && (sel_i == cr_strobe_e'(g));
            end
        end
        assign strobe_o[g] = stb_q;
    end

endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
    import phy_cr_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned POLL_GAP  = 25000,
    parameter int unsigned MAX_POLLS = 10,
    parameter int unsigned RESET_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        cmd_i,
    input  logic [DATA_W-1:0] operand_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] phy_din_o,
    output logic              phy_cap_addr_o,
    output logic              phy_cap_data_o,
    output logic              phy_wr_o,
    output logic              phy_rd_o,
    input  logic              phy_ack_i,
    input  logic [DATA_W-1:0] phy_dout_i
);

    cr_state_e  state_q, state_n;
    cr_strobe_e sel_q, sel_n;
    logic       park_q, park_n;
    logic       rst_bit_q;

    logic       poll, last_poll, restart;
    logic       accept, fin, fin_err, latch_rd;
    logic       load_din;
    logic [NUM_STROBES-1:0] strobes;

    // ------------------------------------------------------------------
    // Next-state and transition events
    // ------------------------------------------------------------------
    always_comb begin
        state_n  = state_q;
        sel_n    = sel_q;
        park_n   = park_q;
        accept   = 1'b0;
        fin      = 1'b0;
        fin_err  = 1'b0;
        latch_rd = 1'b0;
        load_din = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept = 1'b1;
                    park_n = 1'b0;
                    unique case (cr_cmd_e'(cmd_i))
                        CMD_ADDR: begin
                            sel_n    = STB_CAP_ADDR;
                            state_n  = ST_HI;
                            load_din = 1'b1;
                        end
                        CMD_WRITE: begin
                            sel_n    = STB_CAP_DATA;
                            state_n  = ST_HI;
                            load_din = 1'b1;
                        end
                        CMD_READ: begin
                            sel_n    = STB_READ;
                            state_n  = ST_HI;
                        end
                        default: begin
                            fin     = 1'b1;
                            fin_err = 1'b1;
                        end
                    endcase
                end
            end
            ST_HI: begin
                if (poll) begin
                    if (phy_ack_i) begin
                        state_n  = ST_LO;
                        latch_rd = (sel_q == STB_READ);
                    end else if (last_poll) begin
                        state_n = ST_IDLE;
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end
                end
            end
            ST_LO: begin
                if (poll) begin
                    if (!phy_ack_i) begin
                        if (sel_q == STB_CAP_DATA) begin
                            sel_n = STB_WRITE;
                            if (rst_bit_q) begin
                                state_n = ST_IDLE;
                                park_n  = 1'b1;
                                fin     = 1'b1;
                            end else begin
                                state_n = ST_HI;
                            end
                        end else begin
                            state_n = ST_IDLE;
                            fin     = 1'b1;
                        end
                    end else if (last_poll) begin
                        state_n = ST_IDLE;
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign restart = (state_n != state_q);

    // ------------------------------------------------------------------
    // State register
    // ------------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sel_q     <= STB_CAP_ADDR;
            park_q    <= 1'b0;
            rst_bit_q <= 1'b0;
        end else begin
            state_q <= state_n;
            sel_q   <= sel_n;
            park_q  <= park_n;
            if (accept) begin
                rst_bit_q <= operand_i[RESET_BIT];
            end
        end
    end

    // ------------------------------------------------------------------
    // Host-side and data outputs
    // ------------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o    <= 1'b0;
            done_o    <= 1'b0;
            err_o     <= 1'b0;
            rdata_o   <= '0;
            phy_din_o <= '0;
        end else begin
            busy_o <= (state_n != ST_IDLE);
            done_o <= fin;
            if (accept) begin
                err_o <= 1'b0;
            end
            if (fin) begin
                err_o <= fin_err;
            end
            if (latch_rd) begin
                rdata_o <= phy_dout_i;
            end
            if (load_din) begin
                phy_din_o <= operand_i;
            end
        end
    end

    // ------------------------------------------------------------------
    // Sub-blocks
    // ------------------------------------------------------------------
    phy_cr_poll_timer #(
        .POLL_GAP  (POLL_GAP),
        .MAX_POLLS (MAX_POLLS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .active_i  (state_q != ST_IDLE),
        .poll_o    (poll),
        .last_o    (last_poll)
    );

    phy_cr_strobe_drv u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .on_i     ((state_n == ST_HI) || park_n),
        .sel_i    (sel_n),
        .strobe_o (strobes)
    );

    assign phy_cap_addr_o = strobes[STB_CAP_ADDR];
    assign phy_cap_data_o = strobes[STB_CAP_DATA];
    assign phy_wr_o       = strobes[STB_WRITE];
    assign phy_rd_o       = strobes[STB_READ];

endmodule

// File: rtl/phy_cr_master_chk.sv
module phy_cr_master_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [3:0]        strobes,
    input logic              phy_wr_o,
    input logic [DATA_W-1:0] phy_din_o
);

    a_r10_onehot_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    a_r10_din_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((strobes != 4'd0) && (strobes == $past(strobes))) |-> $stable(phy_din_o));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r6_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (strobes == 4'd0));

    a_r7_wr_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_wr_o && !busy_o && !start_i) |=> phy_wr_o);

endmodule

bind phy_cr_master phy_cr_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .strobes   ({phy_rd_o, phy_wr_o, phy_cap_data_o, phy_cap_addr_o}),
    .phy_wr_o  (phy_wr_o),
    .phy_din_o (phy_din_o)
);

// File: tb/phy_cr_master_bench.sv
`timescale 1ns/1ps
module phy_cr_master_bench;

    localparam int unsigned GAP   = 4;
    localparam int unsigned POLLS = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  cmd;
    logic [15:0] operand;
    logic        busy, done, err;
    logic [15:0] rdata, din, dout;
    logic        cap_addr, cap_data, wr, rd;
    logic        ack;

    always #2 clk = ~clk;   // 250 MHz

    phy_cr_master #(.DATA_W(16), .POLL_GAP(GAP), .MAX_POLLS(POLLS), .RESET_BIT(0)) u_phy_cr_master (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd), .operand_i(operand),
        .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
        .phy_din_o(din), .phy_cap_addr_o(cap_addr), .phy_cap_data_o(cap_data),
        .phy_wr_o(wr), .phy_rd_o(rd), .phy_ack_i(ack), .phy_dout_i(dout)
    );

    // ---------------- behavioural PHY responder ----------------
    int          lat = 1;
    bit          never_ack = 1'b0;
    bit          stick_hi = 1'b0;
    logic [7:0]  hist;
    logic [3:0]  prev_s;
    logic        resetting;
    logic [15:0] last_addr, last_data;
    int          wr_count, cd_count, rd_count, done_count, cyc, t_cd, t_wr;
    wire  [3:0]  s = {rd, wr, cap_data, cap_addr};

    function automatic logic [15:0] model_rd(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C96;
    endfunction

    assign dout = model_rd(last_addr);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0; prev_s <= '0; resetting <= 1'b0; ack <= 1'b0;
            last_addr <= '0; last_data <= '0;
            wr_count <= 0; cd_count <= 0; rd_count <= 0; t_cd <= 0; t_wr <= 0;
        end else begin
            hist   <= {hist[6:0], |s};
            prev_s <= s;
            if (s[0] && !prev_s[0]) last_addr <= din;
            if (s[1] && !prev_s[1]) begin last_data <= din; cd_count <= cd_count + 1; t_cd <= cyc; end
            if (s[2] && !prev_s[2]) begin
                wr_count <= wr_count + 1; t_wr <= cyc;
                if (last_data[0]) resetting <= 1'b1;
            end
            if (!s[2]) resetting <= 1'b0;
            if (s[3] && !prev_s[3]) rd_count <= rd_count + 1;
            if (never_ack || resetting || (s[2] && !prev_s[2] && last_data[0])) ack <= 1'b0;
            else if (stick_hi && ack) ack <= 1'b1;
            else ack <= (lat == 0) ? (|s) : hist[lat-1];
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && done) done_count <= done_count + 1;
    end

    // ---------------- checking helpers ----------------
    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int timeout_cycles();
        return 1 + (POLLS - 1) * GAP;
    endfunction

    int  n_cyc;
    bit  got_err;

    // Issue a command; poke_at >= 0 pulses a competing start (write 0x5555) while busy
    task automatic run_op(input logic [1:0] c, input logic [15:0] v, input int poke_at);
        int d0;
        d0 = done_count;
        @(negedge clk);
        start = 1'b1; cmd = c; operand = v;
        @(negedge clk);
        start = 1'b0;
        n_cyc = 0;
        while (!done && n_cyc < 2000) begin
            if (n_cyc == poke_at) begin start = 1'b1; cmd = 2'd1; operand = 16'h5555; end
            else start = 1'b0;
            @(negedge clk);
            n_cyc++;
        end
        start = 1'b0;
        got_err = err;
        chk("R8", "done seen", longint'(done), 1);
        chk("R8", "busy low with done", longint'(busy), 0);
        @(negedge clk);
        chk("R8", "done one cycle", longint'(done), 0);
        chk("R8", "done pulses per command", done_count - d0, 1);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int w0, c0, r0;
        void'($urandom(32'd20240611));
        cyc = 0; done_count = 0;
        rst_n = 1'b0; start = 1'b0; cmd = 2'd0; operand = '0;
        repeat (5) @(negedge clk);
        chk("R1", "busy", longint'(busy), 0);
        chk("R1", "done", longint'(done), 0);
        chk("R1", "err", longint'(err), 0);
        chk("R1", "strobes", longint'(s), 0);
        chk("R1", "din", longint'(din), 0);
        chk("R1", "rdata", longint'(rdata), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 address
        lat = 1;
        run_op(2'd0, 16'h1234, -1);
        chk("R2", "err", longint'(got_err), 0);
        chk("R2", "captured address", longint'(last_addr), 16'h1234);

        // R4 read
        r0 = rd_count;
        run_op(2'd2, 16'h0000, -1);
        chk("R4", "err", longint'(got_err), 0);
        chk("R4", "rdata", longint'(rdata), longint'(model_rd(16'h1234)));
        chk("R4", "read strobes", rd_count - r0, 1);

        // R3 write ordering
        w0 = wr_count; c0 = cd_count;
        run_op(2'd1, 16'h0F0E, -1);
        chk("R3", "err", longint'(got_err), 0);
        chk("R3", "captured data", longint'(last_data), 16'h0F0E);
        chk("R3", "cap-data strobes", cd_count - c0, 1);
        chk("R3", "write strobes", wr_count - w0, 1);
        chk("R3", "write after cap-data", longint'(t_wr > t_cd), 1);

        // R5/R6 never acknowledges
        never_ack = 1'b1;
        run_op(2'd0, 16'h00AA, -1);
        chk("R5", "timeout err", longint'(got_err), 1);
        chk("R5", "timeout latency", n_cyc, timeout_cycles());
        chk("R6", "strobes after timeout", longint'(s), 0);
        never_ack = 1'b0;

        // R6 acknowledge stuck high: write step must not run
        stick_hi = 1'b1; w0 = wr_count;
        run_op(2'd1, 16'h4242, -1);
        chk("R6", "release timeout err", longint'(got_err), 1);
        chk("R6", "no write strobe", wr_count - w0, 0);
        stick_hi = 1'b0;
        repeat (10) @(negedge clk);

        // R7 reset write
        run_op(2'd0, 16'h7F3F, -1);
        w0 = wr_count;
        run_op(2'd1, 16'h0001, -1);
        chk("R7", "reset write err", longint'(got_err), 0);
        chk("R7", "write strobe raised", wr_count - w0, 1);
        repeat (5) @(negedge clk);
        chk("R7", "write strobe parked", longint'(wr), 1);
        run_op(2'd0, 16'h2003, -1);
        chk("R7", "write strobe dropped", longint'(wr), 0);
        chk("R7", "next command ok", longint'(got_err), 0);

        // R9 reserved code
        c0 = cd_count; r0 = rd_count;
        run_op(2'd3, 16'hFFFF, -1);
        chk("R9", "reserved err", longint'(got_err), 1);
        chk("R9", "reserved latency", n_cyc, 0);
        chk("R9", "no strobes", (cd_count - c0) + (rd_count - r0), 0);

        // R8 start while busy ignored
        lat = 3; c0 = cd_count;
        run_op(2'd0, 16'hAAAA, 2);
        chk("R8", "address kept", longint'(last_addr), 16'hAAAA);
        chk("R8", "no cap-data", cd_count - c0, 0);

        // random mix (R2 R3 R4 R10)
        for (int i = 0; i < 40; i++) begin
            logic [1:0]  c;
            logic [15:0] v;
            logic [15:0] a_exp;
            c = 2'($urandom % 3);
            v = 16'($urandom);
            v[0] = 1'b0;
            lat = int'($urandom % 4);
            a_exp = last_addr;
            w0 = wr_count;
            run_op(c, v, -1);
            chk("R10", "random err", longint'(got_err), 0);
            if (c == 2'd0) chk("R2", "random address", longint'(last_addr), longint'(v));
            if (c == 2'd1) begin
                chk("R3", "random data", longint'(last_data), longint'(v));
                chk("R3", "random write count", wr_count - w0, 1);
            end
            if (c == 2'd2) chk("R4", "random rdata", longint'(rdata), longint'(model_rd(a_exp)));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule